// File: doc/BRIEF.md
# Two-Wire Register Slave Port

This block is the serial front end of a small register bank. It listens on a two-wire bus as a slave at the 7-bit address 1101000. Its SCL and SDA inputs are brought into the system clock through flop synchronizers. It drives SDA only through an open-drain enable, and never drives the line high.

After it recognises its own address, it does one of two things:
- **Write transfer:** the first byte sets an internal register pointer, and each later byte goes to the register the pointer selects.
- **Read transfer:** it sends register bytes, starting at whatever the pointer holds.

The pointer steps after every data byte and runs round a nine-entry map, 00h to 08h.

The register contents live outside the block. The block hands the surrounding counter and control logic a per-register write strobe with the byte value, and a per-register read strobe for each byte it loads for sending. It also gives a one-cycle snapshot pulse on every bus START, every STOP and every pointer wrap. The neighbours use these to apply their own access side effects, such as capturing a running count into a holding copy.

Top module: `twowire_reg_slave`

## Requirements
- R1: A first byte after START whose upper seven bits equal 1101000 is acknowledged. The slave holds SDA low through the whole high phase of the ninth clock. Bit 0 of that byte selects the direction: 0 for write, 1 for read.
- R2: A first byte carrying any other address gets no acknowledge. The bus is then ignored until the next START: no data byte is acknowledged, no strobe pulses and the pointer keeps its value.
- R3: START (SDA falling while SCL is high) begins address reception from any state, so a repeated START opens a new transfer. STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R4: The first data byte of a write transfer loads the pointer. A value above 08h loads 00h.
- R5: In a write transfer, every data byte after the pointer byte is acknowledged. It raises for one cycle bit N of the write strobe vector, where N is the current pointer, together with the byte on the write-data output. The pointer then steps by one.
- R6: In a read transfer, bytes are sent most significant bit first. The first byte comes from the current pointer, which keeps its value across transfers and is 00h after reset. Each loaded byte raises bit N of the read strobe vector for one cycle, and the pointer steps after each byte.
- R7: Stepping the pointer from 08h gives 00h, in both write and read transfers.
- R8: A not-acknowledge from the master after a read byte ends the transfer. SDA stays released for all later clocks until a new START.
- R9: The snapshot output pulses for one cycle on each START, each repeated START, each STOP and each pointer wrap from 08h to 00h.
- R10: After reset, SDA is released and the strobe and snapshot outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | High pulls the data line low (open drain) |
| rdData | input | 72 | Current register values, byte N at bits 8N+7 down to 8N |
| regWrStb | output | 9 | One-hot write strobe, bit N for register N |
| regRdStb | output | 9 | One-hot read strobe, bit N for register N |
| wrData | output | 8 | Byte that goes with the write strobe |
| snapPulse | output | 1 | One-cycle pulse on START, STOP and pointer wrap |

## Verification
The bench checks that a read right after reset returns register 00h, which catches a pointer that resets to another value. It checks that a foreign address leaves the pointer where it was by reading afterwards: a slave that half-decodes would acknowledge data or move the pointer.

Write and read bursts are started at 07h and 08h so that they wrap. A pointer that ran on to 09h would write nowhere or return the wrong byte. Counting snapshot pulses across those bursts catches a missing or doubled wrap pulse.

A pointer byte above 08h must land on 00h. After a master not-acknowledge, further clocks must find SDA released; a slave that kept sending would pull the line low.

// File: rtl/twowire_reg_slave_pkg.sv
package twowire_reg_slave_pkg;

  // Bus conditions seen by the control, derived from synchronized lines
  typedef struct packed {
    logic sclLvl;
    logic sclRise;
    logic sclFall;
    logic startCond;
    logic stopCond;
    logic sdaBit;
  } busEvt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic capBit;
    logic loadPtr;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic wrStb;
    logic rdStb;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK
  } phase_t;

endpackage

// File: rtl/twowire_reg_slave_dp.sv
module twowire_reg_slave_dp
  import twowire_reg_slave_pkg::*;
#(
  parameter int NREG        = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [NREG*8-1:0] rdData,
  output busEvt_t           evt,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic [NREG-1:0]   regWrStb,
  output logic [NREG-1:0]   regRdStb,
  output logic [7:0]        wrData,
  output logic              snapPulse
);

  localparam int PTR_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NREG - 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD, sclS, sdaS;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift, curByte;
  logic [PTR_W-1:0] ptr;
  logic [NREG-1:0] ptrHit;
  logic [7:0] regByte [NREG];
  logic wrapNow;

  // Synchronizers and one-cycle history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  assign evt.sclLvl    = sclS;
  assign evt.sclRise   = sclS & ~sclD;
  assign evt.sclFall   = ~sclS & sclD;
  assign evt.startCond = sclS & sclD & sdaD & ~sdaS;
  assign evt.stopCond  = sclS & sclD & ~sdaD & sdaS;
  assign evt.sdaBit    = sdaS;

  // Per-register byte slices and pointer decode
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign regByte[g] = rdData[g*8 +: 8];
    assign ptrHit[g]  = (ptr == PTR_W'(g));
  end

  always_comb begin
    curByte = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ptrHit[i]) curByte = regByte[i];
    end
  end

  assign wrapNow  = ctl.incPtr && (ptr == LAST_PTR);
  assign byteDone = (bitCnt == 4'd8);
  assign rxByte   = rxShift;
  assign txMsb    = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '1;
      ptr       <= '0;
      regWrStb  <= '0;
      regRdStb  <= '0;
      wrData    <= '0;
      snapPulse <= 1'b0;
    end else begin
      if (ctl.clrCnt)      bitCnt <= '0;
      else if (ctl.capBit) bitCnt <= bitCnt + 4'd1;

      if (ctl.capBit) rxShift <= {rxShift[6:0], sdaS};

      if (ctl.loadPtr)
        ptr <= (rxShift < 8'(NREG)) ? rxShift[PTR_W-1:0] : '0;
      else if (ctl.incPtr)
        ptr <= wrapNow ? '0 : ptr + 1'b1;

      if (ctl.loadTx)       txShift <= curByte;
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b1};

      regWrStb <= ctl.wrStb ? ptrHit : '0;
      regRdStb <= ctl.rdStb ? ptrHit : '0;
      if (ctl.wrStb) wrData <= rxShift;

      snapPulse <= evt.startCond | evt.stopCond | wrapNow;
    end
  end

  // R5: at most one write strobe bit in any cycle
  assert_wr_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regWrStb));

  // R6: at most one read strobe bit in any cycle
  assert_rd_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regRdStb));

  // R4: pointer stays inside the map
  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST_PTR);

  // R7: stepping from the last entry lands on entry zero
  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incPtr && ptr == LAST_PTR) |=> (ptr == '0));

  // R9: a START is always followed by a snapshot pulse
  assert_start_snap_R9: assert property (@(posedge clk) disable iff (!rstN)
    evt.startCond |=> snapPulse);

endmodule

// File: rtl/twowire_reg_slave_ctrl.sv
module twowire_reg_slave_ctrl
  import twowire_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic       byteDone,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpCtl_t     ctl,
  output logic       sdaOe
);

  phase_t state, nxt;
  logic rdMode, nxtRd;
  logic ptrPending, nxtPend;
  logic mAck, nxtAck;

  always_comb begin
    nxt     = state;
    nxtRd   = rdMode;
    nxtPend = ptrPending;
    nxtAck  = mAck;
    ctl     = '0;
    if (evt.startCond) begin
      nxt        = ST_ADDR;
      ctl.clrCnt = 1'b1;
    end else if (evt.stopCond) begin
      nxt        = ST_IDLE;
      ctl.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (evt.sclRise && !byteDone) ctl.capBit = 1'b1;
          else if (evt.sclFall && byteDone) begin
            ctl.clrCnt = 1'b1;
            if (rxByte[7:1] == DEV_ADDR) begin
              nxt     = ST_ACK;
              nxtRd   = rxByte[0];
              nxtPend = !rxByte[0];
            end else begin
              nxt = ST_IDLE;
            end
          end
        end
        ST_ACK: begin
          if (evt.sclFall) begin
            ctl.clrCnt = 1'b1;
            if (rdMode) begin
              nxt        = ST_TX;
              ctl.loadTx = 1'b1;
              ctl.rdStb  = 1'b1;
            end else begin
              nxt = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (evt.sclRise && !byteDone) ctl.capBit = 1'b1;
          else if (evt.sclFall && byteDone) begin
            ctl.clrCnt = 1'b1;
            nxt        = ST_ACK;
            if (ptrPending) begin
              ctl.loadPtr = 1'b1;
              nxtPend     = 1'b0;
            end else begin
              ctl.wrStb  = 1'b1;
              ctl.incPtr = 1'b1;
            end
          end
        end
        ST_TX: begin
          if (evt.sclRise && !byteDone) ctl.capBit = 1'b1;
          else if (evt.sclFall) begin
            if (byteDone) begin
              nxt        = ST_MACK;
              ctl.incPtr = 1'b1;
              ctl.clrCnt = 1'b1;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (evt.sclRise) nxtAck = !evt.sdaBit;
          else if (evt.sclFall) begin
            if (mAck) begin
              nxt        = ST_TX;
              ctl.loadTx = 1'b1;
              ctl.rdStb  = 1'b1;
              ctl.clrCnt = 1'b1;
            end else begin
              nxt = ST_IDLE;
            end
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      rdMode     <= 1'b0;
      ptrPending <= 1'b0;
      mAck       <= 1'b0;
    end else begin
      state      <= nxt;
      rdMode     <= nxtRd;
      ptrPending <= nxtPend;
      mAck       <= nxtAck;
    end
  end

  assign sdaOe = (state == ST_ACK) || ((state == ST_TX) && !txMsb);

  // R3: a STOP always leaves SDA released in the next cycle
  assert_stop_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopCond |=> !sdaOe);

  // R1: SDA drive changes only while SCL is low
  assert_sda_stable_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (evt.sclLvl && $past(evt.sclLvl) && !$past(evt.startCond) && !$past(evt.stopCond))
      |-> $stable(sdaOe));

  // R5: write strobe and read load never share a cycle
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wrStb && ctl.loadTx));

endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
  import twowire_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         NREG        = 9,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [NREG*8-1:0] rdData,
  output logic [NREG-1:0]   regWrStb,
  output logic [NREG-1:0]   regRdStb,
  output logic [7:0]        wrData,
  output logic              snapPulse
);

  busEvt_t    evt;
  dpCtl_t     ctl;
  logic       byteDone;
  logic [7:0] rxByte;
  logic       txMsb;

  twowire_reg_slave_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .byteDone (byteDone),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .ctl      (ctl),
    .sdaOe    (sdaOe)
  );

  twowire_reg_slave_dp #(.NREG(NREG), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .ctl       (ctl),
    .rdData    (rdData),
    .evt       (evt),
    .byteDone  (byteDone),
    .rxByte    (rxByte),
    .txMsb     (txMsb),
    .regWrStb  (regWrStb),
    .regRdStb  (regRdStb),
    .wrData    (wrData),
    .snapPulse (snapPulse)
  );

endmodule

// File: tb/twowire_reg_slave_bench.sv
`timescale 1ns/1ps
module twowire_reg_slave_bench;

  localparam int NREG = 9;
  localparam int Q = 5;
  localparam logic [7:0] ADDR_WR = 8'hD0;
  localparam logic [7:0] ADDR_RD = 8'hD1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaOe;
  logic [NREG*8-1:0] rdBus;
  logic [NREG-1:0] regWrStb, regRdStb;
  logic [7:0] wrData;
  logic snapPulse;

  logic [7:0] mem [NREG];
  int wrCount [NREG];
  int rdCount [NREG];
  int wrTotal, rdTotal, snapCount;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  twowire_reg_slave u_twowire_reg_slave (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (scl),
    .sdaIn     (sdaLine),
    .sdaOe     (sdaOe),
    .rdData    (rdBus),
    .regWrStb  (regWrStb),
    .regRdStb  (regRdStb),
    .wrData    (wrData),
    .snapPulse (snapPulse)
  );

  // Register bank model around the slave
  always_comb begin
    for (int i = 0; i < NREG; i++) rdBus[i*8 +: 8] = mem[i];
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) begin
        mem[i] <= 8'(16 * i + 1);
        wrCount[i] <= 0;
        rdCount[i] <= 0;
      end
      wrTotal <= 0;
      rdTotal <= 0;
      snapCount <= 0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (regWrStb[i]) begin
          mem[i] <= wrData;
          wrCount[i] <= wrCount[i] + 1;
          wrTotal <= wrTotal + 1;
        end
        if (regRdStb[i]) begin
          rdCount[i] <= rdCount[i] + 1;
          rdTotal <= rdTotal + 1;
        end
      end
      if (snapPulse) snapCount <= snapCount + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    scl = 1'b1;  tick(Q);
    sdaM = 1'b0; tick(Q);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    scl = 1'b1;  tick(Q);
    sdaM = 1'b1; tick(2 * Q);
  endtask

  task automatic sendBit(input logic b, output logic s);
    sdaM = b;   tick(Q);
    scl = 1'b1; tick(Q);
    s = sdaLine; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) sendBit(b[i], s);
    sendBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sendBit(1'b1, s);
      d = {d[6:0], s};
    end
    sendBit(~ackIt, s);
  endtask

  task automatic testReset();
    check("R10 sdaOe", 32'(sdaOe), 0);
    check("R10 snap", 32'(snapPulse), 0);
    check("R10 wr strobe", 32'(regWrStb), 0);
    check("R10 rd strobe", 32'(regRdStb), 0);
  endtask

  task automatic testReadAfterReset();
    logic a; logic [7:0] d;
    busStart();
    writeByte(ADDR_RD, a);
    check("R1 read address ack", 32'(a), 1);
    readByte(1'b0, d);
    busStop();
    check("R6 pointer zero after reset", 32'(d), 32'h01);
    check("R6 read strobe reg0", 32'(rdCount[0]), 1);
  endtask

  task automatic testWrongAddress();
    logic a; logic [7:0] d; int wr0;
    wr0 = wrTotal;
    busStart();
    writeByte(8'hA0, a);
    check("R2 foreign address no ack", 32'(a), 0);
    writeByte(8'h03, a);
    check("R2 data after foreign address", 32'(a), 0);
    writeByte(8'h55, a);
    busStop();
    check("R2 no write strobe", 32'(wrTotal), 32'(wr0));
    busStart();
    writeByte(ADDR_RD, a);
    readByte(1'b0, d);
    busStop();
    check("R2 pointer kept", 32'(d), 32'h11);
  endtask

  task automatic testWriteBurst();
    logic a;
    busStart();
    writeByte(ADDR_WR, a);
    check("R1 write address ack", 32'(a), 1);
    writeByte(8'h03, a);
    check("R4 pointer byte ack", 32'(a), 1);
    writeByte(8'hA5, a);
    check("R5 data ack", 32'(a), 1);
    writeByte(8'h3C, a);
    busStop();
    check("R5 reg3 data", 32'(mem[3]), 32'hA5);
    check("R5 reg4 data", 32'(mem[4]), 32'h3C);
    check("R5 reg3 single strobe", 32'(wrCount[3]), 1);
    check("R3 released after stop", 32'(sdaOe), 0);
  endtask

  task automatic testRepeatedStartRead();
    logic a; logic [7:0] d;
    busStart();
    writeByte(ADDR_WR, a);
    writeByte(8'h03, a);
    busStart();
    writeByte(ADDR_RD, a);
    check("R3 repeated start address ack", 32'(a), 1);
    readByte(1'b1, d);
    check("R6 first byte", 32'(d), 32'hA5);
    readByte(1'b0, d);
    check("R6 second byte", 32'(d), 32'h3C);
    busStop();
    check("R6 read strobe reg4", 32'(rdCount[4]), 1);
    busStart();
    writeByte(ADDR_RD, a);
    readByte(1'b0, d);
    busStop();
    check("R6 pointer persists", 32'(d), 32'h51);
  endtask

  task automatic testWrapWrite();
    logic a; int s0;
    s0 = snapCount;
    busStart();
    writeByte(ADDR_WR, a);
    writeByte(8'h08, a);
    writeByte(8'h99, a);
    writeByte(8'h66, a);
    busStop();
    check("R7 reg8 written", 32'(mem[8]), 32'h99);
    check("R7 wrapped to reg0", 32'(mem[0]), 32'h66);
    check("R9 start wrap stop pulses", 32'(snapCount - s0), 3);
  endtask

  task automatic testWrapRead();
    logic a; logic [7:0] d; int s0;
    s0 = snapCount;
    busStart();
    writeByte(ADDR_WR, a);
    writeByte(8'h07, a);
    busStart();
    writeByte(ADDR_RD, a);
    readByte(1'b1, d);
    check("R7 read reg7", 32'(d), 32'h71);
    readByte(1'b1, d);
    check("R7 read reg8", 32'(d), 32'h99);
    readByte(1'b0, d);
    check("R7 read wraps to reg0", 32'(d), 32'h66);
    busStop();
    check("R9 restart and wrap pulses", 32'(snapCount - s0), 4);
  endtask

  task automatic testNackRelease();
    logic a; logic s; logic [7:0] d; int lows; int r0;
    busStart();
    writeByte(ADDR_RD, a);
    readByte(1'b0, d);
    check("R8 byte before nack", 32'(d), 32'h11);
    r0 = rdTotal;
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      sendBit(1'b1, s);
      if (!s) lows++;
    end
    check("R8 sda released after nack", 32'(lows), 0);
    check("R8 no further load", 32'(rdTotal), 32'(r0));
    busStop();
  endtask

  task automatic testPointerRange();
    logic a;
    busStart();
    writeByte(ADDR_WR, a);
    writeByte(8'h2F, a);
    writeByte(8'h77, a);
    busStop();
    check("R4 large pointer selects reg0", 32'(mem[0]), 32'h77);
    check("R4 reg0 strobe count", 32'(wrCount[0]), 2);
  endtask

  initial begin
    rstN = 1'b0;
    tick(4);
    rstN = 1'b1;
    tick(4);
    testReset();
    testReadAfterReset();
    testWrongAddress();
    testWriteBurst();
    testRepeatedStartRead();
    testWrapWrite();
    testWrapRead();
    testNackRelease();
    testPointerRange();
    tick(10);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule